// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Master

This block is the master side of a three-wire synchronous serial link: a serial clock, a data-out line and a data-in line. It always transmits and receives at the same time. A one-word transmit holding register sits in front of the shift register, so a word can be queued while the previous one is still on the wire. When that happens, the next frame follows the current one with no pause in the serial clock. Each received word is placed in a receive register.

Two separate single-cycle pulses report progress. The first fires when the holding register has been handed to the shifter and can take a new word. The second fires when a frame ends and its received word is ready. Static configuration inputs set the enable, the bit order, the frame length and the serial clock divider. The serial clock idles high. Data-out changes on falling serial-clock edges, and data-in is sampled on rising edges.

Top module: `serial_dbuf_master`

## Requirements
- R1: After reset `sck` is 1, `mosi` is 0, `busy`, `irq_txe`, `irq_rxe` and `ovr` are 0, and `rx_data` is 0.
- R2: While a frame runs, each half period of `sck` lasts `cfg_div`+1 clock cycles, so `cfg_div`=0 gives a serial clock of half the system clock.
- R3: `cfg_len`=0 selects an 8-bit frame, and any other value n selects an n-bit frame; `tx_data`/`rx_data` use bits n-1..0.
- R4: With `cfg_lsb_first`=0 bit n-1 goes out first; with 1, bit 0 goes out first. `mosi` changes only on falling `sck` edges and is stable at every rising edge.
- R5: At frame end `rx_data` holds the received word right-aligned, with upper bits zero. The first bit received lands in bit n-1 (MSB-first) or bit 0 (LSB-first). `irq_rxe` pulses for one cycle in the same cycle `rx_data` updates.
- R6: `irq_txe` is a one-cycle pulse, raised when the holding register's word is loaded into the shifter.
- R7: A write (`tx_wr`=1) with `cfg_en`=1 and an empty holding register is stored, and `busy` reads 1 in the following cycle.
- R8: A word queued before a frame ends starts the next frame with no idle time. `irq_txe` and `irq_rxe` pulse in the same cycle, and the next falling `sck` edge comes `cfg_div`+1 cycles later.
- R9: When a frame ends with nothing queued, `busy` is 0 and `sck` is 1 in the same cycle that `irq_rxe` pulses.
- R10: A write while the holding register is full and not being drained is dropped and sets `ovr`. `ovr` stays set until `cfg_en` is 0 for a cycle.
- R11: With `cfg_en`=0, writes are ignored, nothing is queued, and `sck` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Block enable; 0 aborts, flushes and clears `ovr` |
| cfg_lsb_first | input | 1 | 1 = LSB first, 0 = MSB first |
| cfg_len | input | LEN_W (4) | Frame length code, 0 = 8 bits |
| cfg_div | input | DIV_W (8) | Half-period of `sck` minus one, in clock cycles |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | DATA_W (16) | Word to transmit |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| rx_data | output | DATA_W (16) | Last received word |
| busy | output | 1 | A frame is running or a word is queued |
| ovr | output | 1 | Sticky overrun flag |
| irq_txe | output | 1 | Pulse: holding register moved to shifter |
| irq_rxe | output | 1 | Pulse: frame complete, `rx_data` valid |

## Verification
The case where two events share a cycle is the end of one frame meeting the reload from the holding register. Then `irq_rxe` and `irq_txe` rise in the same clock, and the shifter must both deliver the old received word and take the new transmit word. The bench provokes this by writing a second word just after the first `irq_txe`. It checks that both pulses are sampled together and that the next falling serial-clock edge comes exactly one half period later. A slave model and the scoreboards then confirm that both words crossed the wire intact.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  typedef enum logic {PH_FALL = 1'b0, PH_RISE = 1'b1} sck_ph_e;

  // length code 0 means an 8-bit frame, otherwise the code is the bit count
  function automatic int unsigned frame_bits(input int unsigned code);
    return (code == 0) ? 8 : code;
  endfunction
endpackage

// File: rtl/sdm_tick.sv
module sdm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)     cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == div);
endmodule

// File: rtl/sdm_txbuf.sv
module sdm_txbuf #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              ovr
);
  logic accept;
  assign accept = en && wr && (!full || take);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
      ovr  <= 1'b0;
    end else if (!en) begin
      full <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (accept) begin
        full <= 1'b1;
        data <= wdata;
      end else if (take) begin
        full <= 1'b0;
      end
      if (wr && full && !take) ovr <= 1'b1;
    end
  end

  a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr && en) |=> ovr);
  a_r11_disabled_empty: assert property (@(posedge clk) disable iff (rst)
    !en |=> !full);
endmodule

// File: rtl/sdm_shift.sv
module sdm_shift
  import sdm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              lsb_cfg,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              miso,
  output logic              take,
  output logic              active,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data,
  output logic              irq_txe,
  output logic              irq_rxe
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam int IW = $clog2(DATA_W);
  localparam logic [CW-1:0] W_C = CW'(DATA_W);

  sck_ph_e           ph;
  logic [CW-1:0]     nbits;
  logic [CW-1:0]     bitn;
  logic              lsb_q;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] rs;
  logic              last;
  logic [IW-1:0]     top_idx;
  logic [DATA_W-1:0] rs_msb;
  logic [DATA_W-1:0] rs_lsb;

  assign last    = (bitn == nbits - 1'b1);
  assign top_idx = IW'(nbits - 1'b1);
  assign rs_msb  = {rs[DATA_W-2:0], miso};
  assign rs_lsb  = {miso, rs[DATA_W-1:1]};
  assign take    = en && buf_full && (!active || (tick && ph == PH_RISE && last));

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      ph      <= PH_FALL;
      nbits   <= CW'(8);
      bitn    <= '0;
      lsb_q   <= 1'b0;
      sh      <= '0;
      rs      <= '0;
      sck     <= 1'b1;
      mosi    <= 1'b0;
      rx_data <= '0;
      irq_txe <= 1'b0;
      irq_rxe <= 1'b0;
    end else begin
      irq_txe <= 1'b0;
      irq_rxe <= 1'b0;
      if (!en) begin
        active <= 1'b0;
        ph     <= PH_FALL;
        sck    <= 1'b1;
      end else if (active && tick) begin
        if (ph == PH_FALL) begin
          sck  <= 1'b0;
          mosi <= lsb_q ? sh[0] : sh[top_idx];
          ph   <= PH_RISE;
        end else begin
          sck  <= 1'b1;
          ph   <= PH_FALL;
          bitn <= bitn + 1'b1;
          sh   <= lsb_q ? (sh >> 1) : (sh << 1);
          rs   <= lsb_q ? rs_lsb : rs_msb;
          if (last) begin
            rx_data <= lsb_q ? (rs_lsb >> (W_C - nbits)) : rs_msb;
            irq_rxe <= 1'b1;
            bitn    <= '0;
            if (!take) active <= 1'b0;
          end
        end
      end
      if (take) begin
        active  <= 1'b1;
        sh      <= buf_data;
        rs      <= '0;
        bitn    <= '0;
        nbits   <= CW'(frame_bits(32'(len_code)));
        lsb_q   <= lsb_cfg;
        irq_txe <= 1'b1;
      end
    end
  end

  a_r4_mosi_steady: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> $stable(mosi));
  a_r9_idle_high: assert property (@(posedge clk) disable iff (rst)
    !active |-> sck);
  a_r6_txe_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_txe |=> !irq_txe);
  a_r5_rxe_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_rxe |=> !irq_rxe);
endmodule

// File: rtl/serial_dbuf_master.sv
module serial_dbuf_master #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = $clog2(DATA_W),
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_lsb_first,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              ovr,
  output logic              irq_txe,
  output logic              irq_rxe
);
  logic              take;
  logic              full;
  logic [DATA_W-1:0] buf_data;
  logic              active;
  logic              tick;

  sdm_txbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .en(cfg_en), .wr(tx_wr), .wdata(tx_data),
    .take(take), .full(full), .data(buf_data), .ovr(ovr)
  );

  sdm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(active), .div(cfg_div), .tick(tick)
  );

  sdm_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst(rst), .en(cfg_en), .tick(tick),
    .buf_full(full), .buf_data(buf_data), .lsb_cfg(cfg_lsb_first),
    .len_code(cfg_len), .miso(miso), .take(take), .active(active),
    .sck(sck), .mosi(mosi), .rx_data(rx_data),
    .irq_txe(irq_txe), .irq_rxe(irq_rxe)
  );

  assign busy = active || full;

  a_r8_joint_reload: assert property (@(posedge clk) disable iff (rst)
    (irq_rxe && irq_txe) |-> busy);
endmodule

// File: tb/sim_serial_dbuf_master.sv
`timescale 1ns/1ps
module sim_serial_dbuf_master;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0, cfg_lsb_first = 1'b0;
  logic [3:0]  cfg_len = 4'd0;
  logic [7:0]  cfg_div = 8'd0;
  logic        tx_wr = 1'b0;
  logic [15:0] tx_data = 16'h0;
  logic        miso = 1'b0;
  logic sck, mosi, busy, ovr, irq_txe, irq_rxe;
  logic [15:0] rx_data;

  int checks = 0, failures = 0, cyc = 0, coincide = 0;
  int tb_bits = 8;
  bit tb_lsb = 1'b0;
  logic [15:0] exp_tx[$];
  logic [15:0] exp_rx[$];
  logic [15:0] rep_q[$];

  always #4 clk = ~clk;

  serial_dbuf_master u0 (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_lsb_first(cfg_lsb_first),
    .cfg_len(cfg_len), .cfg_div(cfg_div), .tx_wr(tx_wr), .tx_data(tx_data),
    .miso(miso), .sck(sck), .mosi(mosi), .rx_data(rx_data), .busy(busy),
    .ovr(ovr), .irq_txe(irq_txe), .irq_rxe(irq_rxe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mask(input logic [15:0] v);
    return v & 16'((32'h1 << tb_bits) - 1);
  endfunction

  task automatic wr_word(input logic [15:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_data = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic send(input logic [15:0] tx, input logic [15:0] rep);
    exp_tx.push_back(mask(tx));
    rep_q.push_back(rep);
    exp_rx.push_back(mask(rep));
    wr_word(tx);
  endtask

  task automatic wait_rxe();
    int t = 0;
    do begin @(negedge clk); t++; end while (!irq_rxe && t < 2000);
    check(irq_rxe === 1'b1, "R5 frame end seen", irq_rxe, 1);
  endtask

  task automatic wait_txe();
    int t = 0;
    do begin @(negedge clk); t++; end while (!irq_txe && t < 2000);
    check(irq_txe === 1'b1, "R6 reload seen", irq_txe, 1);
  endtask

  // slave model: presents reply bits on falling sck
  int sbit = 0;
  logic [15:0] cur = 16'h0;
  always @(negedge sck) begin
    if (rst === 1'b0) begin
      if (sbit == 0) cur = (rep_q.size() > 0) ? rep_q.pop_front() : 16'h0;
      miso = tb_lsb ? cur[sbit] : cur[tb_bits-1-sbit];
      sbit = (sbit + 1 == tb_bits) ? 0 : sbit + 1;
    end
  end

  // mosi capture on rising sck, compared against transmit scoreboard
  int mbit = 0;
  logic [15:0] cap = 16'h0;
  always @(posedge sck) begin
    if (rst === 1'b0) begin
      cap[tb_lsb ? mbit : tb_bits-1-mbit] = mosi;
      mbit++;
      if (mbit == tb_bits) begin
        if (exp_tx.size() == 0) check(1'b0, "R4 unexpected frame", cap, 0);
        else begin
          logic [15:0] e;
          e = exp_tx.pop_front();
          check(cap == e, "R3/R4 mosi word", cap, e);
        end
        mbit = 0; cap = 16'h0;
      end
    end
  end

  // receive monitor
  always @(negedge clk) begin
    if (rst === 1'b0 && irq_rxe === 1'b1) begin
      if (irq_txe === 1'b1) coincide++;
      if (exp_rx.size() == 0) check(1'b0, "R5 unexpected rx", rx_data, 0);
      else begin
        logic [15:0] e;
        e = exp_rx.pop_front();
        check(rx_data == e, "R5 rx_data", rx_data, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check(sck === 1'b1 && mosi === 1'b0, "R1 lines", {sck, mosi}, 2);
    check(busy === 1'b0 && ovr === 1'b0, "R1 flags", {busy, ovr}, 0);
    check(irq_txe === 1'b0 && irq_rxe === 1'b0 && rx_data === 16'h0, "R1 irq/rx", rx_data, 0);
    rst = 1'b0;
    @(negedge clk);

    // MSB first, length code 0 = 8 bits, div 0
    cfg_en = 1; cfg_lsb_first = 0; cfg_len = 0; cfg_div = 0; tb_bits = 8; tb_lsb = 0;
    send(16'hA5, 16'h3C);
    check(busy === 1'b1, "R7 busy after write", busy, 1);
    @(negedge clk);
    check(irq_txe === 1'b1, "R6 txe pulse", irq_txe, 1);
    @(negedge clk);
    check(irq_txe === 1'b0, "R6 txe one cycle", irq_txe, 0);
    wait_rxe();
    check(busy === 1'b0 && sck === 1'b1, "R9 idle after frame", {busy, sck}, 1);

    // LSB first, 5-bit frame
    cfg_lsb_first = 1; cfg_len = 5; tb_bits = 5; tb_lsb = 1;
    send(16'h0013, 16'h000B);
    wait_rxe();

    // MSB first, 12 bits, div 2: sck period
    cfg_lsb_first = 0; cfg_len = 12; cfg_div = 2; tb_bits = 12; tb_lsb = 0;
    send(16'h0ABC, 16'h05A3);
    begin
      int n = 0;
      logic prev = 1'b1;
      while (!(prev == 1'b1 && sck == 1'b0)) begin prev = sck; @(negedge clk); end
      prev = sck;
      do begin @(negedge clk); n++; if (prev == 1'b1 && sck == 1'b0) break; prev = sck; end while (n < 100);
      check(n == 6, "R2 sck period", n, 6);
    end
    wait_rxe();

    // back-to-back frames, div 1
    cfg_len = 0; cfg_div = 1; tb_bits = 8;
    send(16'h0081, 16'h007E);
    wait_txe();
    send(16'h0042, 16'h0099);
    wait_rxe();
    check(irq_txe === 1'b1, "R8 reload with frame end", irq_txe, 1);
    check(busy === 1'b1, "R8 still busy", busy, 1);
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (sck !== 1'b0 && n < 50);
      check(n == 2, "R8 no gap", n, 2);
    end
    wait_rxe();
    check(busy === 1'b0 && sck === 1'b1, "R9 idle after burst", {busy, sck}, 1);

    // overrun
    cfg_div = 0;
    send(16'h0011, 16'h0022);
    send(16'h0033, 16'h0044);
    wr_word(16'h00EE);
    check(ovr === 1'b1, "R10 overrun set", ovr, 1);
    wait_rxe();
    wait_rxe();
    check(ovr === 1'b1, "R10 overrun sticky", ovr, 1);
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R10 dropped word not sent", busy, 0);
    cfg_en = 0;
    @(negedge clk);
    check(ovr === 1'b0, "R10 cleared by disable", ovr, 0);

    // disabled write ignored
    wr_word(16'h0055);
    check(busy === 1'b0, "R11 no queue when disabled", busy, 0);
    repeat (30) @(negedge clk);
    check(sck === 1'b1 && busy === 1'b0, "R11 idle when disabled", {sck, busy}, 2);
    cfg_en = 1;
    repeat (5) @(negedge clk);
    check(busy === 1'b0 && sck === 1'b1, "R11 nothing held", {busy, sck}, 1);

    repeat (20) @(negedge clk);
    check(exp_tx.size() == 0 && exp_rx.size() == 0, "R5 scoreboard drained",
          exp_tx.size() + exp_rx.size(), 0);
    check(coincide >= 2, "R8 joint pulses", coincide, 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule